// File: doc/BRIEF.md
# Stream-to-Memory Frame Writer with Completion Marker

This block takes one frame of data words from a ready/valid stream input and stores each word in memory through a simple write-request master port. Word k of a frame goes to the byte address (base + data offset + 4·k). Once every data write has been acknowledged, the block writes a completion marker word to (base + marker offset). A consumer that cleared the buffer to zero can poll the marker word and then trust the data beneath it. The usual setup puts the marker at offset 0 and the data at offset 4, so the marker sits directly before the samples.

Software sets the base address, the two offsets and the frame length in words. It also sets a status input word. It then pulses `start`. The block captures these settings, handles exactly one frame and pulses `done`. With `auto_restart` held high, it recaptures the settings and begins the next frame without a new start. Only one memory write is ever in flight: the stream input is held not-ready from the moment a word is taken until that word's write has been acknowledged. A stream `last` flag that arrives before the full frame length ends the frame early and sets a short-frame status bit.

Top module: `frame_sink_writer`

## Requirements
- R1: Data word k of a frame (k counted from 0) is written with address base_addr + data_offset + 4·k (modulo 2^32) and data equal to the k-th accepted stream word, in stream order.
- R2: frame_words is a count of 32-bit words. When the frame does not end early, exactly frame_words data writes precede the marker write. frame_words = 0 produces only the marker write.
- R3: The marker write is issued only after the write response of every data word. It goes to base_addr + bell_offset, and its data is {status_in[31:16] captured at frame start, seq[15:0]}. seq is 1 for the first frame after reset and increases by one per completed frame, so it is never zero.
- R4: At most one write is outstanding. s_ready is low from a stream handshake until the response of the resulting write. A write request keeps wr_addr and wr_data stable until wr_ready. No stream word is lost or written twice under backpressure.
- R5: If s_last is seen with word k while k+1 < frame_words, the frame ends after that word's write, the marker is still written, and status_out bit 0 is set.
- R6: status_out has the following layout: bit 0 is the short flag of the last completed frame, bit 1 is high while a frame is in progress, and bits 31:16 hold the number of data words written in the last completed frame. All other bits are zero.
- R7: done pulses for exactly one cycle, in the cycle the marker write's response arrives. A start pulse while a frame is in progress is ignored. Without auto-restart the block then goes idle with s_ready low.
- R8: With auto_restart high when the marker response arrives, a new frame begins at once with freshly captured settings and a seq value one higher.
- R9: base_addr, data_offset, bell_offset, frame_words and status_in are captured when a frame begins. Changes to them during the frame have no effect on that frame.
- R10: After reset, s_ready, wr_valid, done and status_out are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one frame (used only while idle) |
| auto_restart | input | 1 | Begin the next frame automatically after completion |
| base_addr | input | 32 | Byte address of the buffer |
| data_offset | input | 32 | Byte offset of data word 0 |
| bell_offset | input | 32 | Byte offset of the completion marker word |
| frame_words | input | 16 | Words per frame |
| status_in | input | 32 | Software status word; upper half goes into the marker |
| status_out | output | 32 | Short flag, busy, words of last frame |
| done | output | 1 | One-cycle pulse at frame completion |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word accepted when high with s_valid |
| s_data | input | 32 | Stream word |
| s_last | input | 1 | Final stream word of a frame |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted when high with wr_valid |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data |
| wr_resp | input | 1 | One-cycle write completion response |

## Verification
Most results follow a fixed latency:
- s_ready rises one cycle after the clock edge that captures `start`.
- A write request appears one cycle after a stream handshake.
- s_ready returns one cycle after a data write's response.
- The marker request follows the last data response by one cycle.
- done is high in the same cycle as the marker response.
- status_out takes its new count and short flag at the following edge.

The bench drives inputs on the falling edge and samples five nanoseconds later, before the next rising edge, so every handshake is judged on the values the design sees at that edge. A scoreboard queue receives each expected address/data pair ahead of time, and the monitor compares them in order. Random ready and response delays stretch these latencies without changing the order or content of the writes.

// File: rtl/fsw_pkg.sv
package fsw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RECV,
      ST_WDATA,
      ST_WACK,
      ST_BELL,
      ST_BACK
   } fsw_state_t;

endpackage

// File: rtl/fsw_addr_gen.sv
module fsw_addr_gen #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16,
   parameter int BYTES  = 4,
   parameter bit ACCUM  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [CNT_W-1:0]  idx,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] doff,
   input  logic [ADDR_W-1:0] boff,
   output logic [ADDR_W-1:0] data_addr,
   output logic [ADDR_W-1:0] bell_addr
);
   localparam int SH = $clog2(BYTES);

   if ((1 << SH) != BYTES) begin : g_bad_bytes
      $error("fsw_addr_gen: BYTES must be a power of two");
   end

   logic [ADDR_W-1:0] data_base_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_base_q <= '0;
         bell_addr   <= '0;
      end else if (load) begin
         data_base_q <= base + doff;
         bell_addr   <= base + boff;
      end
   end

   if (ACCUM) begin : g_accum
      logic [ADDR_W-1:0] ptr_q;
      wire unused_idx = ^idx;
      always_ff @(posedge clk) begin
         if (!rst_n)     ptr_q <= '0;
         else if (load)  ptr_q <= base + doff;
         else if (step)  ptr_q <= ptr_q + ADDR_W'(BYTES);
      end
      assign data_addr = ptr_q;
   end else begin : g_scaled
      assign data_addr = data_base_q + (ADDR_W'(idx) << SH);
   end

   // Consecutive data words sit one word apart.
   assert_word_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> data_addr == $past(data_addr) + ADDR_W'(BYTES));

endmodule

// File: rtl/fsw_bell_ctr.sv
module fsw_bell_ctr #(
   parameter int DATA_W = 32,
   parameter int SEQ_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              frame_end,
   input  logic [DATA_W-1:0] status_in,
   output logic [DATA_W-1:0] bell_word
);
   localparam int TAG_W = DATA_W - SEQ_W;

   logic [SEQ_W-1:0] seq_q;
   logic [SEQ_W-1:0] seq_nx;
   logic [TAG_W-1:0] tag_q;
   wire  unused_status_low = ^status_in[SEQ_W-1:0];

   assign seq_nx = seq_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seq_q <= SEQ_W'(1);
         tag_q <= '0;
      end else begin
         if (frame_end) seq_q <= (seq_nx == '0) ? SEQ_W'(1) : seq_nx;
         if (load)      tag_q <= status_in[DATA_W-1:SEQ_W];
      end
   end

   assign bell_word = {tag_q, seq_q};

   // The marker sequence never reads as cleared memory.
   assert_seq_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      seq_q != '0);

endmodule

// File: rtl/fsw_ctrl.sv
module fsw_ctrl
   import fsw_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              auto_restart,
   input  logic [CNT_W-1:0]  frame_words,
   input  logic              s_valid,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_last,
   input  logic              wr_ready,
   input  logic              wr_resp,
   output logic              s_ready,
   output logic              wr_valid,
   output logic              is_bell,
   output logic              load,
   output logic              step,
   output logic              frame_end,
   output logic              busy,
   output logic              short_q,
   output logic [CNT_W-1:0]  cnt,
   output logic [DATA_W-1:0] data_q
);
   fsw_state_t       st;
   logic [CNT_W-1:0] words_q;
   logic [CNT_W-1:0] cnt_nx;
   logic             last_q;

   assign cnt_nx    = cnt + 1'b1;
   assign load      = (st == ST_IDLE && start) ||
                      (st == ST_BACK && wr_resp && auto_restart);
   assign step      = (st == ST_WACK) && wr_resp;
   assign frame_end = (st == ST_BACK) && wr_resp;
   assign busy      = (st != ST_IDLE);
   assign s_ready   = (st == ST_RECV);
   assign wr_valid  = (st == ST_WDATA) || (st == ST_BELL);
   assign is_bell   = (st == ST_BELL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         words_q <= '0;
         short_q <= 1'b0;
         last_q  <= 1'b0;
         data_q  <= '0;
      end else begin
         unique case (st)
            ST_IDLE: ;
            ST_RECV: if (s_valid) begin
               data_q <= s_data;
               last_q <= s_last;
               st     <= ST_WDATA;
            end
            ST_WDATA: if (wr_ready) st <= ST_WACK;
            ST_WACK: if (wr_resp) begin
               cnt <= cnt_nx;
               if (cnt_nx == words_q) begin
                  st <= ST_BELL;
               end else if (last_q) begin
                  short_q <= 1'b1;
                  st      <= ST_BELL;
               end else begin
                  st <= ST_RECV;
               end
            end
            ST_BELL: if (wr_ready) st <= ST_BACK;
            ST_BACK: if (wr_resp) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
         if (load) begin
            cnt     <= '0;
            short_q <= 1'b0;
            words_q <= frame_words;
            st      <= (frame_words == '0) ? ST_BELL : ST_RECV;
         end
      end
   end

   // A full frame reaches the marker only with every word counted.
   assert_full_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BELL && !short_q) |-> cnt == words_q);

   // An early end always leaves fewer words than requested.
   assert_short_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      short_q |-> cnt < words_q);

   // A start during a frame does not restart the word count.
   assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WACK && start && !wr_resp) |=> cnt == $past(cnt));

endmodule

// File: rtl/frame_sink_writer.sv
module frame_sink_writer #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter int SEQ_W  = 16,
   parameter bit ACCUM  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              auto_restart,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [ADDR_W-1:0] data_offset,
   input  logic [ADDR_W-1:0] bell_offset,
   input  logic [CNT_W-1:0]  frame_words,
   input  logic [DATA_W-1:0] status_in,
   output logic [DATA_W-1:0] status_out,
   output logic              done,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_last,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   input  logic              wr_resp
);
   localparam int BYTES   = DATA_W / 8;
   localparam int CNT_LSB = 16;

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("frame_sink_writer: DATA_W must be whole bytes");
   end
   if (SEQ_W < 1 || SEQ_W >= DATA_W) begin : g_bad_seq
      $error("frame_sink_writer: SEQ_W must lie inside DATA_W");
   end
   if (CNT_LSB + CNT_W > DATA_W) begin : g_bad_cnt
      $error("frame_sink_writer: CNT_W does not fit the status word");
   end

   logic              is_bell, load, step, frame_end, busy, short_q;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] data_q, bell_word;
   logic [ADDR_W-1:0] data_addr, bell_addr;
   logic [CNT_W-1:0]  last_cnt_q;
   logic              last_short_q;
   logic              pend_q;

   fsw_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .auto_restart(auto_restart),
      .frame_words(frame_words), .s_valid(s_valid), .s_data(s_data),
      .s_last(s_last), .wr_ready(wr_ready), .wr_resp(wr_resp),
      .s_ready(s_ready), .wr_valid(wr_valid), .is_bell(is_bell),
      .load(load), .step(step), .frame_end(frame_end), .busy(busy),
      .short_q(short_q), .cnt(cnt), .data_q(data_q)
   );

   fsw_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BYTES(BYTES), .ACCUM(ACCUM)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step), .idx(cnt),
      .base(base_addr), .doff(data_offset), .boff(bell_offset),
      .data_addr(data_addr), .bell_addr(bell_addr)
   );

   fsw_bell_ctr #(.DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_bell (
      .clk(clk), .rst_n(rst_n), .load(load), .frame_end(frame_end),
      .status_in(status_in), .bell_word(bell_word)
   );

   assign wr_addr = is_bell ? bell_addr : data_addr;
   assign wr_data = is_bell ? bell_word : data_q;
   assign done    = frame_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_cnt_q   <= '0;
         last_short_q <= 1'b0;
         pend_q       <= 1'b0;
      end else begin
         if (frame_end) begin
            last_cnt_q   <= cnt;
            last_short_q <= short_q;
         end
         if (wr_valid && wr_ready) pend_q <= 1'b1;
         else if (wr_resp)         pend_q <= 1'b0;
      end
   end

   always_comb begin
      status_out                     = '0;
      status_out[0]                  = last_short_q;
      status_out[1]                  = busy;
      status_out[CNT_LSB +: CNT_W]   = last_cnt_q;
   end

   // Stream is closed while a write awaits its response.
   assert_ready_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> !pend_q);

   // Only one write in flight.
   assert_single_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !pend_q);

   // A stalled request holds its contents.
   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

   // Completion only on a response.
   assert_done_on_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> wr_resp && $past(wr_valid && wr_ready) == 1'b0 || done |-> pend_q);

endmodule

// File: tb/frame_sink_writer_test.sv
`timescale 1ns/1ps
module frame_sink_writer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, auto_restart = 1'b0;
   logic [31:0] base_addr = '0, data_offset = '0, bell_offset = '0;
   logic [15:0] frame_words = '0;
   logic [31:0] status_in = '0;
   logic [31:0] status_out;
   logic        done;
   logic        s_valid = 1'b0, s_last = 1'b0;
   logic [31:0] s_data = '0;
   logic        s_ready;
   logic        wr_valid, wr_ready, wr_resp;
   logic [31:0] wr_addr, wr_data;

   int checks = 0, bad = 0, done_cnt = 0, resp_due = 0;
   bit stall = 1'b0;
   string tag = "R1";
   logic [63:0] expq[$];
   logic [15:0] seq_exp = 16'd1;

   always #10 clk = ~clk;

   frame_sink_writer uut (
      .clk(clk), .rst_n(rst_n), .start(start), .auto_restart(auto_restart),
      .base_addr(base_addr), .data_offset(data_offset), .bell_offset(bell_offset),
      .frame_words(frame_words), .status_in(status_in), .status_out(status_out),
      .done(done), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
      .s_last(s_last), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_addr(wr_addr), .wr_data(wr_data), .wr_resp(wr_resp)
   );

   task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", t, act, exp);
      end
   endtask

   task automatic push(input logic [31:0] a, input logic [31:0] d);
      expq.push_back({a, d});
   endtask

   task automatic push_bell(input logic [31:0] a, input logic [31:0] st);
      push(a, {st[31:16], seq_exp});
      seq_exp = (seq_exp == 16'hFFFF) ? 16'd1 : seq_exp + 16'd1;
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic send(input logic [31:0] d, input logic l);
      bit ok;
      @(negedge clk);
      s_valid = 1'b1; s_data = d; s_last = l;
      ok = 1'b0;
      while (!ok) begin
         #5 ok = s_ready;
         if (!ok) @(negedge clk);
      end
      @(negedge clk);
      s_valid = 1'b0; s_last = 1'b0;
   endtask

   task automatic wait_done(input int target, input string t);
      int n = 0;
      while (done_cnt < target && n < 3000) begin
         @(negedge clk); n++;
      end
      repeat (3) @(negedge clk);
      #5 chk({t, " done count"}, done_cnt, target);
   endtask

   // memory side: ready pattern and delayed response
   initial begin
      wr_ready = 1'b0; wr_resp = 1'b0;
      forever begin
         @(negedge clk);
         wr_resp = 1'b0;
         if (resp_due > 0) begin
            resp_due--;
            if (resp_due == 0) wr_resp = 1'b1;
         end
         wr_ready = stall ? ($urandom % 3 == 0) : 1'b1;
      end
   end

   // monitor: compares writes against the scoreboard
   initial begin
      forever begin
         @(negedge clk); #5;
         if (rst_n) begin
            if (done) done_cnt++;
            if (wr_valid && wr_ready) begin
               checks++;
               if (expq.size() == 0) begin
                  bad++;
                  $display("FAIL %s unexpected write actual=%h:%h expected=none", tag, wr_addr, wr_data);
               end else begin
                  logic [63:0] e;
                  e = expq.pop_front();
                  if ({wr_addr, wr_data} !== e) begin
                     bad++;
                     $display("FAIL %s write actual=%h:%h expected=%h:%h",
                              tag, wr_addr, wr_data, e[63:32], e[31:0]);
                  end
               end
               resp_due = 1 + (stall ? int'($urandom % 3) : 0);
            end
         end
      end
   end

   initial begin
      #4000000;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks + 1, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #5;
      chk("R10 s_ready", {31'b0, s_ready}, 32'h0);
      chk("R10 wr_valid", {31'b0, wr_valid}, 32'h0);
      chk("R10 done", {31'b0, done}, 32'h0);
      chk("R10 status_out", status_out, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Frame A: marker before data, start ignored mid-frame
      tag = "R1";
      base_addr = 32'h0000_1000; data_offset = 32'd4; bell_offset = 32'd0;
      frame_words = 16'd4; status_in = 32'hABCD_0000;
      for (int k = 0; k < 4; k++) push(32'h1004 + 4 * k, 32'hA000_0000 + k);
      push_bell(32'h1000, status_in);
      pulse_start();
      #5 chk("R6 busy bit", {31'b0, status_out[1]}, 32'h1);
      send(32'hA000_0000, 1'b0);
      send(32'hA000_0001, 1'b0);
      tag = "R7";
      pulse_start();
      send(32'hA000_0002, 1'b0);
      send(32'hA000_0003, 1'b1);
      wait_done(1, "R7");
      chk("R2 status after full frame", status_out, 32'h0004_0000);
      chk("R7 idle s_ready", {31'b0, s_ready}, 32'h0);
      chk("R3 scoreboard drained", expq.size(), 0);

      // Frame B: backpressure, settings changed mid-frame
      tag = "R4";
      stall = 1'b1;
      base_addr = 32'h2000_0000; data_offset = 32'h40; bell_offset = 32'h3C;
      frame_words = 16'd6; status_in = 32'h1234_5678;
      for (int k = 0; k < 6; k++) push(32'h2000_0040 + 4 * k, 32'hB0B0_0000 ^ (k * 32'h1111));
      push_bell(32'h2000_003C, 32'h1234_5678);
      pulse_start();
      send(32'hB0B0_0000, 1'b0);
      tag = "R9";
      base_addr = 32'hDEAD_0000; data_offset = 32'h8; bell_offset = 32'h100;
      frame_words = 16'd2; status_in = 32'hFFFF_FFFF;
      for (int k = 1; k < 6; k++) send(32'hB0B0_0000 ^ (k * 32'h1111), k == 5);
      wait_done(2, "R9");
      chk("R4 status after stalled frame", status_out, 32'h0006_0000);
      chk("R4 scoreboard drained", expq.size(), 0);

      // Short frame
      tag = "R5";
      base_addr = 32'h0000_8000; data_offset = 32'd4; bell_offset = 32'd0;
      frame_words = 16'd5; status_in = 32'h5A5A_0000;
      for (int k = 0; k < 3; k++) push(32'h8004 + 4 * k, 32'hC000_0010 + k);
      push_bell(32'h8000, status_in);
      pulse_start();
      for (int k = 0; k < 3; k++) send(32'hC000_0010 + k, k == 2);
      wait_done(3, "R5");
      chk("R5 short status", status_out, 32'h0003_0001);
      chk("R5 s_ready after short", {31'b0, s_ready}, 32'h0);

      // Zero-length frame
      tag = "R2";
      stall = 1'b0;
      frame_words = 16'd0; status_in = 32'h0F0F_0000;
      push_bell(32'h8000, status_in);
      pulse_start();
      wait_done(4, "R2");
      chk("R2 zero-length status", status_out, 32'h0000_0000);
      chk("R2 zero-length drained", expq.size(), 0);

      // Auto-restart: two frames from one start
      tag = "R8";
      auto_restart = 1'b1;
      base_addr = 32'h0001_0000; data_offset = 32'd4; bell_offset = 32'd0;
      frame_words = 16'd2; status_in = 32'h7777_0000;
      for (int f = 0; f < 2; f++) begin
         for (int k = 0; k < 2; k++) push(32'h1_0004 + 4 * k, 32'hD000_0000 + 16 * f + k);
         push_bell(32'h1_0000, 32'h7777_0000);
      end
      pulse_start();
      send(32'hD000_0000, 1'b0);
      send(32'hD000_0001, 1'b1);
      send(32'hD000_0010, 1'b0);
      auto_restart = 1'b0;
      send(32'hD000_0011, 1'b1);
      wait_done(6, "R8");
      chk("R8 status after restart frame", status_out, 32'h0002_0000);
      chk("R8 idle after restart", {31'b0, s_ready}, 32'h0);
      repeat (10) @(negedge clk);
      chk("R4 no extra writes", expq.size(), 0);

      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule